// File: doc/BRIEF.md
# Exception Entry and Reset State Controller

This block sits in the control unit of a small 32-bit RISC core. It takes over the program counter and the status registers when an exception or an interrupt is accepted. It picks the return address to keep in the saved-PC register and copies the live status word into the saved-status register. It then raises the status word into privileged, blocked, bank-1 mode and sends the fetch unit to a handler address. That address is the vector base plus an offset that depends on whether the event is a general exception or an interrupt.

The return address depends on the class of the event and on where the faulting instruction sits. A re-executing exception returns to the faulting instruction, or to the delayed branch whose slot it occupied. A completed exception or an interrupt returns past the instruction. A conditional delayed branch needs care: it returns to its target when taken and to the delay slot when not taken.

The block also holds the reset values of the control registers. A request accepted while the blocked bit is already set is a nested fault, and it forces the same reset state. A return strobe restores the PC and the status word from the saved copies. The core loads the status word and the vector base through two plain load inputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A re-executing exception (`exc_completed`=0, `exc_is_int`=0) outside a delay slot and not on a conditional branch sets `spc` to `exc_pc`.
- R2: A re-executing exception with `exc_in_dslot`=1 sets `spc` to `exc_branch_pc`, the address of the delayed branch that owns the slot.
- R3: A completed exception (`exc_completed`=1), or any request with `exc_is_int`=1, sets `spc` to `exc_pc` + 2 (instructions are 2 bytes wide).
- R4: A completed exception or interrupt with `exc_cond_branch`=1 and `exc_cond_taken`=1 sets `spc` to `exc_branch_target`.
- R5: With `exc_cond_branch`=1 and `exc_cond_taken`=0, `spc` is set to `exc_pc` + 2 (the delay-slot address) for both classes. This rule takes precedence over R2.
- R6: While `rst` is high, and after it falls, `vbr`=0x00000000 and `pc_next`=0xA0000000. `sr`=0x700000F0: MD is bit 30, RB bit 29, BL bit 28 and the mask I3..I0 is bits 7:4. `spc`=`ssr`=0, and `pc_load`=`multi_exc_reset`=0.
- R7: A request processed while `sr` bit 28 (BL) is 1 restores the R6 values of `sr`, `vbr` and `pc_next`. In that cycle it pulses `pc_load` and `multi_exc_reset` and leaves `spc` and `ssr` unchanged.
- R8: On a normal entry, `ssr` takes the old `sr` at the same edge that `spc` is written. `sr` becomes the old value with bits 30, 29 and 28 set and every other bit kept.
- R9: On a normal entry, `pc_next` becomes `vbr`+0x100 for an exception or `vbr`+0x600 for an interrupt, and `pc_load` is 1 for exactly that cycle.
- R10: `rte_strobe` sampled at an edge with no entry pending sets `pc_next`=`spc` and `sr`=`ssr` at that edge and pulses `pc_load`.
- R11: A request sampled at edge t is processed at edge t+1, and one request is processed per edge. An entry being processed overrides `rte_strobe`, `sr_load` and `vbr_load` at that edge, and `rte_strobe` overrides both loads.
- R12: `sr_load` and `vbr_load` write `sr_load_data` and `vbr_load_data` at the sampling edge when neither an entry nor a return is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception or interrupt request |
| exc_is_int | input | 1 | Request is an interrupt |
| exc_completed | input | 1 | 1 = completed class, 0 = re-executing class |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| exc_branch_pc | input | 32 | Address of the delayed branch owning the slot |
| exc_cond_branch | input | 1 | Faulting instruction is a conditional delayed branch |
| exc_cond_taken | input | 1 | Condition of that branch is true |
| exc_branch_target | input | 32 | Target address of that branch |
| rte_strobe | input | 1 | Return from exception |
| sr_load | input | 1 | Load the status word |
| sr_load_data | input | 32 | Status word to load |
| vbr_load | input | 1 | Load the vector base |
| vbr_load_data | input | 32 | Vector base to load |
| pc_load | output | 1 | One-cycle strobe: fetch from pc_next |
| pc_next | output | 32 | Redirect address |
| sr | output | 32 | Status word |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved PC |
| vbr | output | 32 | Vector base |
| multi_exc_reset | output | 1 | One-cycle strobe: nested fault forced a reset |

## Verification
The assertions watch every cycle for the parts of the behaviour that hold whatever the addresses are. After reset the R6 state must be present. A normal entry must copy the old `sr` into `ssr` and raise the three mode bits, a nested fault must land on the reset state with its strobe, and a return must bring back `spc` and `ssr`. The return-address choice across the class, delay-slot and conditional-branch combinations needs concrete addresses, so only the bench scenarios can show it. The same holds for the handler offsets and the order of priority between an entry, a return strobe and a load arriving at the same edge. The bench's reference model is compared with all outputs on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN  = 32;
  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;

  typedef enum logic {CLS_REEXEC = 1'b0, CLS_DONE = 1'b1} exc_cls_e;

  typedef struct packed {
    logic            is_int;
    exc_cls_e        cls;
    logic [XLEN-1:0] pc;
    logic            in_ds;
    logic [XLEN-1:0] br_pc;
    logic            cbr;
    logic            ctaken;
    logic [XLEN-1:0] tgt;
  } exc_req_t;

  localparam logic [XLEN-1:0] SR_MODE_BITS =
    (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_BL);
  localparam logic [XLEN-1:0] SR_RESET =
    SR_MODE_BITS | (XLEN'((1 << SR_IM_W) - 1) << SR_IM_LSB);
endpackage

// File: rtl/exc_req_stage.sv
module exc_req_stage
  import exc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  exc_req_t in_req,
  output logic     out_valid,
  output exc_req_t out_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_req   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_req <= in_req;
    end
  end
endmodule

// File: rtl/exc_ret_sel.sv
module exc_ret_sel
  import exc_pkg::*;
#(
  parameter int INSN_BYTES = 2
) (
  input  exc_req_t        req,
  output logic [XLEN-1:0] ret_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic completes;
  assign completes = req.is_int || (req.cls == CLS_DONE);

  always_comb begin
    if (req.cbr && !req.ctaken)
      ret_pc = req.pc + STEP;          // slot after an untaken branch
    else if (completes)
      ret_pc = (req.cbr && req.ctaken) ? req.tgt : req.pc + STEP;
    else
      ret_pc = req.in_ds ? req.br_pc : req.pc;
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] OFF_GEN = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFF_INT = 32'h0000_0600
) (
  input  logic [XLEN-1:0] vbr_q,
  input  logic [XLEN-1:0] sr_q,
  input  logic            is_int,
  output logic [XLEN-1:0] handler_pc,
  output logic [XLEN-1:0] entry_sr
);
  assign handler_pc = vbr_q + (is_int ? OFF_INT : OFF_GEN);
  assign entry_sr   = sr_q | SR_MODE_BITS;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int               INSN_BYTES = 2,
  parameter logic [XLEN-1:0]  RESET_PC   = 32'hA000_0000,
  parameter logic [XLEN-1:0]  OFF_GEN    = 32'h0000_0100,
  parameter logic [XLEN-1:0]  OFF_INT    = 32'h0000_0600
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_valid,
  input  logic            exc_is_int,
  input  logic            exc_completed,
  input  logic [XLEN-1:0] exc_pc,
  input  logic            exc_in_dslot,
  input  logic [XLEN-1:0] exc_branch_pc,
  input  logic            exc_cond_branch,
  input  logic            exc_cond_taken,
  input  logic [XLEN-1:0] exc_branch_target,
  input  logic            rte_strobe,
  input  logic            sr_load,
  input  logic [XLEN-1:0] sr_load_data,
  input  logic            vbr_load,
  input  logic [XLEN-1:0] vbr_load_data,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] sr,
  output logic [XLEN-1:0] ssr,
  output logic [XLEN-1:0] spc,
  output logic [XLEN-1:0] vbr,
  output logic            multi_exc_reset
);
  exc_req_t        req_in, pend;
  logic            pend_v;
  logic [XLEN-1:0] ret_pc, handler_pc, entry_sr;

  always_comb begin
    req_in.is_int = exc_is_int;
    req_in.cls    = exc_completed ? CLS_DONE : CLS_REEXEC;
    req_in.pc     = exc_pc;
    req_in.in_ds  = exc_in_dslot;
    req_in.br_pc  = exc_branch_pc;
    req_in.cbr    = exc_cond_branch;
    req_in.ctaken = exc_cond_taken;
    req_in.tgt    = exc_branch_target;
  end

  exc_req_stage u_stage (
    .clk(clk), .rst(rst), .in_valid(exc_valid), .in_req(req_in),
    .out_valid(pend_v), .out_req(pend)
  );

  exc_ret_sel #(.INSN_BYTES(INSN_BYTES)) u_ret (
    .req(pend), .ret_pc(ret_pc)
  );

  exc_vec_gen #(.OFF_GEN(OFF_GEN), .OFF_INT(OFF_INT)) u_vec (
    .vbr_q(vbr), .sr_q(sr), .is_int(pend.is_int),
    .handler_pc(handler_pc), .entry_sr(entry_sr)
  );

  logic nested;
  assign nested = pend_v && sr[SR_BL];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= SR_RESET; vbr <= '0; pc_next <= RESET_PC;
      spc <= '0; ssr <= '0; pc_load <= 1'b0; multi_exc_reset <= 1'b0;
    end else begin
      pc_load         <= 1'b0;
      multi_exc_reset <= 1'b0;
      if (nested) begin
        sr <= SR_RESET; vbr <= '0; pc_next <= RESET_PC;
        pc_load <= 1'b1; multi_exc_reset <= 1'b1;
      end else if (pend_v) begin
        spc <= ret_pc; ssr <= sr; sr <= entry_sr;
        pc_next <= handler_pc; pc_load <= 1'b1;
      end else if (rte_strobe) begin
        pc_next <= spc; sr <= ssr; pc_load <= 1'b1;
      end else begin
        if (sr_load)  sr  <= sr_load_data;
        if (vbr_load) vbr <= vbr_load_data;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $fell(rst) |-> (sr == SR_RESET && vbr == '0 && pc_next == RESET_PC)); // R6
  AST_NESTED_TO_RESET: assert property (@(posedge clk) disable iff (rst)
    (pend_v && sr[SR_BL]) |=> (multi_exc_reset && pc_next == RESET_PC && sr == SR_RESET
                               && $stable(spc) && $stable(ssr))); // R7
  AST_SSR_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !sr[SR_BL]) |=> (ssr == $past(sr) && pc_load && !multi_exc_reset)); // R8
  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !sr[SR_BL]) |=> (sr == ($past(sr) | SR_MODE_BITS))); // R8
  AST_RTE_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (rte_strobe && !pend_v) |=> (pc_next == $past(spc) && sr == $past(ssr) && pc_load)); // R10
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic        exc_valid = 0, exc_is_int = 0, exc_completed = 0;
  logic [31:0] exc_pc = 0, exc_branch_pc = 0, exc_branch_target = 0;
  logic        exc_in_dslot = 0, exc_cond_branch = 0, exc_cond_taken = 0;
  logic        rte_strobe = 0, sr_load = 0, vbr_load = 0;
  logic [31:0] sr_load_data = 0, vbr_load_data = 0;
  logic        pc_load, multi_exc_reset;
  logic [31:0] pc_next, sr, ssr, spc, vbr;

  exc_entry_ctrl dut_i (.*);

  int checks = 0, errors = 0;
  string tag = "R6";

  // behavioural reference model
  logic [31:0] m_sr, m_ssr, m_spc, m_vbr, m_pc;
  logic        m_load, m_mx;
  logic        q_v, q_int, q_done, q_ds, q_cbr, q_ct;
  logic [31:0] q_pc, q_bpc, q_tgt;

  function automatic logic [31:0] ref_ret();
    if (q_cbr && !q_ct) return q_pc + 2;
    if (q_done || q_int) return (q_cbr && q_ct) ? q_tgt : q_pc + 2;
    return q_ds ? q_bpc : q_pc;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sr = 32'h700000F0; m_vbr = 0; m_pc = 32'hA0000000;
      m_spc = 0; m_ssr = 0; m_load = 0; m_mx = 0; q_v = 0;
    end else begin
      m_load = 0; m_mx = 0;
      if (q_v && m_sr[28]) begin
        m_sr = 32'h700000F0; m_vbr = 0; m_pc = 32'hA0000000; m_load = 1; m_mx = 1;
      end else if (q_v) begin
        m_spc = ref_ret(); m_ssr = m_sr; m_sr = m_sr | 32'h70000000;
        m_pc = m_vbr + (q_int ? 32'h600 : 32'h100); m_load = 1;
      end else if (rte_strobe) begin
        m_pc = m_spc; m_sr = m_ssr; m_load = 1;
      end else begin
        if (sr_load) m_sr = sr_load_data;
        if (vbr_load) m_vbr = vbr_load_data;
      end
      q_v = exc_valid;
      if (exc_valid) begin
        q_int = exc_is_int; q_done = exc_completed; q_ds = exc_in_dslot;
        q_cbr = exc_cond_branch; q_ct = exc_cond_taken;
        q_pc = exc_pc; q_bpc = exc_branch_pc; q_tgt = exc_branch_target;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_pc !== 'x) begin
      checks++;
      if ({pc_load, multi_exc_reset, pc_next, sr, ssr, spc, vbr} !==
          {m_load, m_mx, m_pc, m_sr, m_ssr, m_spc, m_vbr}) begin
        errors++;
        $display("FAIL %s model mismatch actual=%h/%h/%h/%h/%h ld=%b mx=%b expected=%h/%h/%h/%h/%h ld=%b mx=%b",
                 tag, pc_next, sr, ssr, spc, vbr, pc_load, multi_exc_reset,
                 m_pc, m_sr, m_ssr, m_spc, m_vbr, m_load, m_mx);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_sr(logic [31:0] d);
    @(negedge clk); sr_load = 1; sr_load_data = d;
    @(negedge clk); sr_load = 0;
  endtask

  task automatic raise(logic intr, logic done, logic [31:0] pc, logic ds,
                       logic [31:0] bpc, logic cbr, logic ct, logic [31:0] tgt);
    @(negedge clk);
    exc_valid = 1; exc_is_int = intr; exc_completed = done; exc_pc = pc;
    exc_in_dslot = ds; exc_branch_pc = bpc; exc_cond_branch = cbr;
    exc_cond_taken = ct; exc_branch_target = tgt;
    @(negedge clk); exc_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R6 sr during reset", sr, 32'h700000F0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R6 pc", pc_next, 32'hA0000000);
    chk("R6 vbr", vbr, 0);
    chk("R6 sr", sr, 32'h700000F0);
    chk("R6 strobes", {31'd0, pc_load | multi_exc_reset}, 0);

    tag = "R12";
    @(negedge clk); vbr_load = 1; vbr_load_data = 32'h8000_0000;
    @(negedge clk); vbr_load = 0;
    chk("R12 vbr load", vbr, 32'h8000_0000);
    load_sr(32'h0000_00A3);
    chk("R12 sr load", sr, 32'h0000_00A3);

    tag = "R1";
    raise(0, 0, 32'h1000, 0, 0, 0, 0, 0);
    chk("R1 spc", spc, 32'h1000);
    chk("R9 handler general", pc_next, 32'h8000_0100);
    chk("R8 ssr", ssr, 32'h0000_00A3);
    chk("R8 sr forced", sr, 32'h7000_00A3);

    tag = "R2";
    load_sr(32'h0000_0010);
    raise(0, 0, 32'h2002, 1, 32'h2000, 0, 0, 0);
    chk("R2 spc", spc, 32'h2000);

    tag = "R3";
    load_sr(0);
    raise(0, 1, 32'h3000, 0, 0, 0, 0, 0);
    chk("R3 spc completed", spc, 32'h3002);
    load_sr(0);
    raise(1, 0, 32'h3100, 0, 0, 0, 0, 0);
    chk("R3 spc interrupt", spc, 32'h3102);
    chk("R9 handler interrupt", pc_next, 32'h8000_0600);

    tag = "R4";
    load_sr(0);
    raise(0, 1, 32'h4000, 0, 0, 1, 1, 32'h4400);
    chk("R4 spc target", spc, 32'h4400);

    tag = "R5";
    load_sr(0);
    raise(0, 1, 32'h5000, 0, 0, 1, 0, 32'h5400);
    chk("R5 spc completed untaken", spc, 32'h5002);
    load_sr(0);
    raise(0, 0, 32'h5100, 1, 32'h50F0, 1, 0, 32'h5400);
    chk("R5 spc reexec untaken", spc, 32'h5102);

    tag = "R10";
    load_sr(32'h0000_0055);
    raise(0, 0, 32'h6000, 0, 0, 0, 0, 0);
    @(negedge clk); rte_strobe = 1;
    @(negedge clk); rte_strobe = 0;
    chk("R10 pc from spc", pc_next, 32'h6000);
    chk("R10 sr from ssr", sr, 32'h0000_0055);

    tag = "R11";
    load_sr(0);
    @(negedge clk); exc_valid = 1; exc_is_int = 0; exc_completed = 0;
    exc_pc = 32'h7000; exc_in_dslot = 0; exc_cond_branch = 0;
    @(negedge clk); exc_valid = 0; rte_strobe = 1; sr_load = 1; sr_load_data = 0;
    chk("R11 latency", {31'd0, pc_load}, 0);
    @(negedge clk); rte_strobe = 0; sr_load = 0;
    chk("R11 entry wins", pc_next, 32'h8000_0100);
    chk("R11 spc", spc, 32'h7000);

    tag = "R7";
    raise(0, 0, 32'h9000, 0, 0, 0, 0, 0);
    chk("R7 pc reset", pc_next, 32'hA000_0000);
    chk("R7 vbr reset", vbr, 0);
    chk("R7 spc kept", spc, 32'h7000);
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule